// File: doc/BRIEF.md
# Dual Phase-Frequency Detector with Lock and Test Output

This block serves two synthesizer channels, channel 0 (high band) and channel 1 (low band). Each channel has a digital phase-frequency detector. The detector compares a single-cycle pulse from the reference divider with a single-cycle pulse from the feedback divider. It then issues pump-up and pump-down requests to the charge-pump control logic downstream. A per-channel polarity bit sets the sense of the pump requests. A per-channel gain bit goes to the pump logic through a register.

Both requests stay high together for a short fixed time, so small corrections still appear when the loop is locked. Pump activity gives a raw "idle" lock indication for each channel. A filter that counts comparison windows gives a settled lock flag.

One test/lock pin, written as a data bit plus an output enable, carries one signal chosen by a 4-bit function word. The choices are:
- constant levels or high impedance;
- the raw lock indications, driven push-pull or open-drain;
- the filtered lock flag;
- any of the four divider pulse streams.

A powerdown flag releases the pin.

Top module: `dual_pfd_lockmux`

## Requirements
- R1: A reference pulse sets the channel's internal up request and a feedback pulse sets its down request. Each request stays set until both are set.
- R2: Once both requests are set, both stay set for exactly HOLD clocks (default 2). They then clear in the same cycle. During that time the pulse inputs are ignored.
- R3: The pump outputs are registered one clock after the requests. With polarity 1, pump_up carries the up request and pump_dn carries the down request. With polarity 0 the two are swapped.
- R4: gain_q equals cp_gain delayed by one clock.
- R5: Function codes 3, 4 and 5 drive the pin (oe=1). The data is the idle level (1 when neither request is set) of channel 0, of channel 1, or of both ANDed, respectively.
- R6: Function codes 6, 7 and 8 use the same three idle levels in open-drain form. The pin is released (oe=0) while the level is 1, and driven low (oe=1, data=0) while it is 0.
- R7: A comparison window is a run of cycles with at least one request set. Code 9 drives the AND of both channels' filtered lock flags. A channel's flag sets when LOCKN (default 4) consecutive windows each last at most HOLD+TOL cycles (TOL default 0). The flag clears at the end of the first longer window.
- R8: Code 0 releases the pin. Code 1 drives 0 and code 2 drives 1. Codes 10, 11, 12 and 13 drive the reference pulse of channel 0, the feedback pulse of channel 0, the reference pulse of channel 1 and the feedback pulse of channel 1. Codes 14 and 15 release the pin.
- R9: While pdn is high, the pin is released with data 0 from the next clock on, whatever the function code.
- R10: Synchronous reset clears the requests, filters, pump outputs, gain_q, tl_data and tl_oe.
- R11: The pin outputs are registered: they reflect the function code, pdn and the internal state of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 2 | Reference-divider pulse per channel |
| fb_pulse | input | 2 | Feedback-divider pulse per channel |
| cp_pol | input | 2 | Pump polarity per channel (1 = positive tuning slope) |
| cp_gain | input | 2 | Pump current select per channel |
| fsel | input | 4 | Test/lock pin function code |
| pdn | input | 1 | Powerdown, releases the pin |
| pump_up | output | 2 | Registered pump-up request per channel |
| pump_dn | output | 2 | Registered pump-down request per channel |
| gain_q | output | 2 | Registered gain select per channel |
| tl_data | output | 1 | Test/lock pin data |
| tl_oe | output | 1 | Test/lock pin output enable |

## Verification
The assertions assume that divider pulses last one clock. They also assume that no pulse reaches a channel while both of its requests are in the HOLD interval, so a dropped pulse is never counted as a fault. The stimulus keeps to this. It spaces pulses ten clocks apart and limits the phase offset between a channel's two streams to at most three clocks either way, which always finishes the hold before the next pulse. Aligned streams, positive and negative offsets, polarity flips and every function code are driven within that envelope.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [3:0] {
    TL_HIZ  = 4'd0,
    TL_LO   = 4'd1,
    TL_HI   = 4'd2,
    TL_PP0  = 4'd3,
    TL_PP1  = 4'd4,
    TL_PPB  = 4'd5,
    TL_OD0  = 4'd6,
    TL_OD1  = 4'd7,
    TL_ODB  = 4'd8,
    TL_DLD  = 4'd9,
    TL_MR0  = 4'd10,
    TL_MN0  = 4'd11,
    TL_MR1  = 4'd12,
    TL_MN1  = 4'd13,
    TL_RSV0 = 4'd14,
    TL_RSV1 = 4'd15
  } tl_sel_e;

  function automatic logic is_open_drain(input logic [3:0] code);
    return (code == TL_OD0) || (code == TL_OD1) || (code == TL_ODB);
  endfunction
endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  input  logic fb_i,
  input  logic pol_i,
  output logic up_o,
  output logic dn_o,
  output logic active_o
);
  localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic             up_q, dn_q;
  logic [CNT_W-1:0] hold_cnt;
  logic             both;

  assign both     = up_q & dn_q;
  assign active_o = up_q | dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      hold_cnt <= '0;
    end else if (both) begin
      if (hold_cnt == CNT_W'(HOLD - 1)) begin
        up_q     <= 1'b0;
        dn_q     <= 1'b0;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end else begin
      up_q <= up_q | ref_i;
      dn_q <= dn_q | fb_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= pol_i ? up_q : dn_q;
      dn_o <= pol_i ? dn_q : up_q;
    end
  end

  a_r1_ref_sets_up: assert property (@(posedge clk) disable iff (rst)
    (!both && ref_i) |=> up_q);
  a_r1_fb_sets_dn: assert property (@(posedge clk) disable iff (rst)
    (!both && fb_i) |=> dn_q);
  a_r3_pos_polarity: assert property (@(posedge clk) disable iff (rst)
    pol_i |=> (up_o == $past(up_q)) && (dn_o == $past(dn_q)));
  a_r3_neg_polarity: assert property (@(posedge clk) disable iff (rst)
    !pol_i |=> (up_o == $past(dn_q)) && (dn_o == $past(up_q)));

  generate
    if (HOLD > 1) begin : g_minw
      a_r2_min_width: assert property (@(posedge clk) disable iff (rst)
        $rose(up_q && dn_q) |=> (up_q && dn_q));
    end
  endgenerate
endmodule

// File: rtl/lock_filter.sv
module lock_filter #(
  parameter int HOLD  = 2,
  parameter int TOL   = 0,
  parameter int LOCKN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  output logic lock_o
);
  localparam int LIMIT   = HOLD + TOL;
  localparam int RUN_MAX = LIMIT + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int GOOD_W  = $clog2(LOCKN + 1);

  logic [RUN_W-1:0]  run_q;
  logic [GOOD_W-1:0] good_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      good_q <= '0;
      lock_o <= 1'b0;
    end else if (active_i) begin
      if (run_q != RUN_W'(RUN_MAX)) run_q <= run_q + 1'b1;
    end else if (run_q != '0) begin
      run_q <= '0;
      if (run_q <= RUN_W'(LIMIT)) begin
        if (good_q != GOOD_W'(LOCKN)) good_q <= good_q + 1'b1;
        if (good_q >= GOOD_W'(LOCKN - 1)) lock_o <= 1'b1;
      end else begin
        good_q <= '0;
        lock_o <= 1'b0;
      end
    end
  end

  a_r7_long_window_drops: assert property (@(posedge clk) disable iff (rst)
    (!active_i && (run_q > RUN_W'(LIMIT))) |=> !lock_o);
  a_r7_lock_only_at_window_end: assert property (@(posedge clk) disable iff (rst)
    (active_i && !lock_o) |=> !lock_o);
endmodule

// File: rtl/tl_mux.sv
module tl_mux
  import pfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] sel_i,
  input  logic       pdn_i,
  input  logic [1:0] idle_i,
  input  logic       dlock_i,
  input  logic [1:0] ref_i,
  input  logic [1:0] fb_i,
  output logic       data_o,
  output logic       oe_o
);
  logic d_n, oe_n;

  always_comb begin
    d_n  = 1'b0;
    oe_n = 1'b1;
    case (tl_sel_e'(sel_i))
      TL_HIZ:  oe_n = 1'b0;
      TL_LO:   d_n  = 1'b0;
      TL_HI:   d_n  = 1'b1;
      TL_PP0:  d_n  = idle_i[0];
      TL_PP1:  d_n  = idle_i[1];
      TL_PPB:  d_n  = &idle_i;
      TL_OD0:  begin d_n = idle_i[0]; oe_n = ~idle_i[0]; end
      TL_OD1:  begin d_n = idle_i[1]; oe_n = ~idle_i[1]; end
      TL_ODB:  begin d_n = &idle_i;   oe_n = ~(&idle_i); end
      TL_DLD:  d_n  = dlock_i;
      TL_MR0:  d_n  = ref_i[0];
      TL_MN0:  d_n  = fb_i[0];
      TL_MR1:  d_n  = ref_i[1];
      TL_MN1:  d_n  = fb_i[1];
      default: oe_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || pdn_i) begin
      data_o <= 1'b0;
      oe_o   <= 1'b0;
    end else begin
      data_o <= d_n;
      oe_o   <= oe_n;
    end
  end

  a_r9_pdn_release: assert property (@(posedge clk) disable iff (rst)
    pdn_i |=> (!oe_o && !data_o));
  a_r6_open_drain: assert property (@(posedge clk) disable iff (rst)
    (!pdn_i && is_open_drain(sel_i)) |=> (oe_o != data_o));
  a_r8_hiz_code: assert property (@(posedge clk) disable iff (rst)
    (!pdn_i && (sel_i == TL_HIZ)) |=> !oe_o);
  a_r5_push_pull: assert property (@(posedge clk) disable iff (rst)
    (!pdn_i && (sel_i >= 4'd3) && (sel_i <= 4'd5)) |=> oe_o);
endmodule

// File: rtl/dual_pfd_lockmux.sv
module dual_pfd_lockmux #(
  parameter int HOLD  = 2,
  parameter int TOL   = 0,
  parameter int LOCKN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ref_pulse,
  input  logic [1:0] fb_pulse,
  input  logic [1:0] cp_pol,
  input  logic [1:0] cp_gain,
  input  logic [3:0] fsel,
  input  logic       pdn,
  output logic [1:0] pump_up,
  output logic [1:0] pump_dn,
  output logic [1:0] gain_q,
  output logic       tl_data,
  output logic       tl_oe
);
  localparam int NCH = 2;

  logic [NCH-1:0] active;
  logic [NCH-1:0] lock_f;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      pfd_core #(.HOLD(HOLD)) u_pfd (
        .clk      (clk),
        .rst      (rst),
        .ref_i    (ref_pulse[g]),
        .fb_i     (fb_pulse[g]),
        .pol_i    (cp_pol[g]),
        .up_o     (pump_up[g]),
        .dn_o     (pump_dn[g]),
        .active_o (active[g])
      );
      lock_filter #(.HOLD(HOLD), .TOL(TOL), .LOCKN(LOCKN)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .active_i (active[g]),
        .lock_o   (lock_f[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) gain_q <= '0;
    else     gain_q <= cp_gain;
  end

  tl_mux u_mux (
    .clk     (clk),
    .rst     (rst),
    .sel_i   (fsel),
    .pdn_i   (pdn),
    .idle_i  (~active),
    .dlock_i (&lock_f),
    .ref_i   (ref_pulse),
    .fb_i    (fb_pulse),
    .data_o  (tl_data),
    .oe_o    (tl_oe)
  );

  a_r4_gain_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (gain_q == $past(cp_gain)));
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (pump_up == 2'b00) && (pump_dn == 2'b00) && !tl_oe && (gain_q == 2'b00));
endmodule

// File: tb/dual_pfd_lockmux_bench.sv
module dual_pfd_lockmux_bench;
  localparam int HOLD  = 2;
  localparam int TOL   = 0;
  localparam int LOCKN = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ref_pulse = '0, fb_pulse = '0, cp_pol = 2'b11, cp_gain = '0;
  logic [3:0] fsel = '0;
  logic       pdn = 1'b0;
  logic [1:0] pump_up, pump_dn, gain_q;
  logic       tl_data, tl_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  dual_pfd_lockmux #(.HOLD(HOLD), .TOL(TOL), .LOCKN(LOCKN)) u_dual_pfd_lockmux (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .cp_pol(cp_pol), .cp_gain(cp_gain), .fsel(fsel), .pdn(pdn),
    .pump_up(pump_up), .pump_dn(pump_dn), .gain_q(gain_q),
    .tl_data(tl_data), .tl_oe(tl_oe)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_up[2], m_dn[2], m_cnt[2], m_run[2], m_good[2], m_lock[2];
  int e_pu[2], e_pd[2], e_gain[2];
  int e_d, e_oe;
  int last_sel;
  bit last_pdn, last_rst;

  always @(posedge clk) begin
    int idle[2];
    int sig;
    last_sel = int'(fsel);
    last_pdn = pdn;
    last_rst = rst;
    for (int c = 0; c < 2; c++) idle[c] = (m_up[c] == 0 && m_dn[c] == 0) ? 1 : 0;
    if (rst) begin
      e_d = 0; e_oe = 0;
    end else if (pdn) begin
      e_d = 0; e_oe = 0;
    end else begin
      e_oe = 1;
      case (int'(fsel))
        0: begin e_d = 0; e_oe = 0; end
        1: e_d = 0;
        2: e_d = 1;
        3: e_d = idle[0];
        4: e_d = idle[1];
        5: e_d = idle[0] & idle[1];
        6, 7, 8: begin
          sig = (fsel == 6) ? idle[0] : (fsel == 7) ? idle[1] : (idle[0] & idle[1]);
          e_d = sig; e_oe = 1 - sig;
        end
        9: e_d = m_lock[0] & m_lock[1];
        10: e_d = int'(ref_pulse[0]);
        11: e_d = int'(fb_pulse[0]);
        12: e_d = int'(ref_pulse[1]);
        13: e_d = int'(fb_pulse[1]);
        default: begin e_d = 0; e_oe = 0; end
      endcase
    end
    for (int c = 0; c < 2; c++) begin
      if (rst) begin
        m_up[c] = 0; m_dn[c] = 0; m_cnt[c] = 0; m_run[c] = 0;
        m_good[c] = 0; m_lock[c] = 0; e_pu[c] = 0; e_pd[c] = 0; e_gain[c] = 0;
      end else begin
        e_pu[c] = cp_pol[c] ? m_up[c] : m_dn[c];
        e_pd[c] = cp_pol[c] ? m_dn[c] : m_up[c];
        e_gain[c] = int'(cp_gain[c]);
        if (m_up[c] != 0 || m_dn[c] != 0) m_run[c]++;
        else if (m_run[c] != 0) begin
          if (m_run[c] <= HOLD + TOL) begin
            if (m_good[c] < LOCKN) m_good[c]++;
            if (m_good[c] == LOCKN) m_lock[c] = 1;
          end else begin
            m_good[c] = 0; m_lock[c] = 0;
          end
          m_run[c] = 0;
        end
        if (m_up[c] != 0 && m_dn[c] != 0) begin
          if (m_cnt[c] == HOLD - 1) begin m_up[c] = 0; m_dn[c] = 0; m_cnt[c] = 0; end
          else m_cnt[c]++;
        end else begin
          if (ref_pulse[c]) m_up[c] = 1;
          if (fb_pulse[c])  m_dn[c] = 1;
        end
      end
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string pin_tag(input int sel, input bit p, input bit r);
    if (r) return "R10";
    if (p) return "R9";
    if (sel >= 3 && sel <= 5) return "R5";
    if (sel >= 6 && sel <= 8) return "R6";
    if (sel == 9) return "R7";
    return "R8";
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      string pt;
      for (int c = 0; c < 2; c++) begin
        check(last_rst ? "R10" : "R1/R2/R3", "pump_up", int'(pump_up[c]), e_pu[c]);
        check(last_rst ? "R10" : "R1/R2/R3", "pump_dn", int'(pump_dn[c]), e_pd[c]);
        check(last_rst ? "R10" : "R4", "gain_q", int'(gain_q[c]), e_gain[c]);
      end
      pt = pin_tag(last_sel, last_pdn, last_rst);
      check(pt, "tl_data (R11 timing)", int'(tl_data), e_d);
      check(pt, "tl_oe (R11 timing)", int'(tl_oe), e_oe);
    end
  end

  // drive `periods` comparison periods of 10 clocks; fb of channel c at phase off[c]
  task automatic run(input int periods, input int off0, input int off1);
    for (int i = 0; i < periods * 10; i++) begin
      @(negedge clk);
      ref_pulse[0] = (i % 10 == 0);
      ref_pulse[1] = (i % 10 == 0);
      fb_pulse[0]  = (i % 10 == off0);
      fb_pulse[1]  = (i % 10 == off1);
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", wd, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: aligned streams lock, offset breaks lock, realign relocks
    fsel = 4'd9;
    run(8, 0, 0);
    run(3, 2, 0);
    run(6, 0, 0);
    run(3, 0, 8);
    // every function code with mixed offsets, R5 R6 R8
    for (int s = 0; s < 16; s++) begin
      @(negedge clk);
      fsel = 4'(s);
      cp_gain = 2'(s);
      run(2, 0, 3);
      run(1, 7, 0);
    end
    // R3 polarity swapped on each channel
    cp_pol = 2'b01; fsel = 4'd3;
    run(3, 2, 9);
    cp_pol = 2'b10; fsel = 4'd7;
    run(3, 9, 2);
    cp_pol = 2'b11;
    // R9 powerdown overrides drive codes
    pdn = 1'b1;
    for (int s = 1; s < 14; s++) begin
      @(negedge clk);
      fsel = 4'(s);
      run(1, 1, 0);
    end
    pdn = 1'b0;
    fsel = 4'd2;
    run(2, 0, 0);
    // R10 reset mid-activity
    fsel = 4'd9;
    run(6, 0, 0);
    @(negedge clk);
    rst = 1'b1;
    ref_pulse = 2'b11;
    repeat (2) @(negedge clk);
    ref_pulse = 2'b00;
    rst = 1'b0;
    run(2, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule